// File: doc/BRIEF.md
# Dual Divider Bank Clock Crosspoint

This block turns two incoming clocks into six routed clock outputs. The fast VCO clock is the block's own clock. The slower reference clock (REF) is sampled on it. Each of the two divider banks follows either every VCO cycle or every REF rising edge. From that chosen source a bank makes a programmable divide-by-N tap and two fixed small-ratio taps. Bank 1 has /2 and /3 taps. Bank 2 has /2 and /4 taps. The fixed taps restart at every terminal count of the /N counter, so their rising edges coincide with the /N rising edge whenever N satisfies the divisibility rule for that tap.

Six output lanes each pick one of seven sources through a 3-bit code: raw REF, or one of the six bank taps. Each lane also has its own enable, which drives a pad enable; a disabled lane is high-impedance and its clock is held low. Configuration arrives as byte writes (address, data) from a serial slave placed in front of the block. A change of divisor or bank source is held back until the bank's current period ends, so no short pulse appears on the output.

REF must toggle at most at half the VCO rate. All outputs are registered in the VCO domain.

Top module: `clk_xbar`

## Requirements
- R1: After reset every enable is 0, so `oe_o` is 6'b000000 and every `clk_o` bit is low until the enable byte is written.
- R2: Address 0x09 bits 5..0 are the lane enables, with bit i controlling lane i (lane 0 = first output). A 1 sets `oe_o[i]`. A 0 clears `oe_o[i]` and holds `clk_o[i]` low.
- R3: Address 0x0C configures bank 1 and address 0x47 configures bank 2. In each, bit 7 selects the source (1 = VCO clock, 0 = REF) and bits 6..0 hold N. The /N tap has a period of N source ticks, for N from 4 to 127.
- R4: The /N tap is high for floor(N/2) source ticks per period, so even N gives exactly 50% duty.
- R5: Bank 1 provides /2 and /3 taps; bank 2 provides /2 and /4 taps. When N is a multiple of the tap ratio, each tap has a period equal to its ratio. Its high time is 1 tick for /2 and /3, and 2 ticks for /4.
- R6: Bank 1 /2 rises together with bank 1 /N when N1 is a multiple of 4, and bank 1 /3 does so when N1 is 6. Bank 2 /2 rises together with bank 2 /N when N2 is a multiple of 4, and bank 2 /4 does so when N2 is a multiple of 8.
- R7: The lane codes are: 0 = REF, 1 = bank1 /N, 2 = bank1 /2, 3 = bank1 /3, 4 = bank2 /N, 5 = bank2 /2, 6 = bank2 /4, 7 = reserved. The six codes are packed MSB first into one 18-bit field, lane 0 first: address 0x44 bits 7..0, then 0x45 bits 7..0, then 0x46 bits 7..6.
- R8: Lane code 7 holds that lane's clock low even when its enable is set; `oe_o` still follows the enable.
- R9: A new N or source for a bank is applied only at the bank's next terminal count. Every high and low phase seen on the /N output is therefore a full phase of either the old setting or the new one.
- R10: Writes to any address other than 0x09, 0x0C, 0x44, 0x45, 0x46 and 0x47 change no output or setting.
- R11: A bank set to REF advances once per REF rising edge. Lane code 0 passes REF itself to the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock; clocks all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock, at most half the VCO rate |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| clk_o | output | 6 | Lane clock outputs, lane 0 at bit 0 |
| oe_o | output | 6 | Lane pad enables; 0 means high-impedance |

## Verification
A bank counter holding a wrong phase or a stale divisor shows up within one output period. It appears as a /N high or low time that differs from floor(N/2) or its complement, or as a fixed tap whose rising edge falls away from the /N rising edge. A wrong decode or packing of the lane code field routes the wrong tap, which is visible as a wrong period on the very next measured cycle. A divisor applied before the terminal count shows as a truncated phase right after the write. The bench therefore measures run lengths across every reconfiguration instead of sampling only steady state.

// File: rtl/clk_xbar_pkg.sv
package clk_xbar_pkg;
    localparam int NUM_OUT   = 6;
    localparam int SEL_W     = 3;
    localparam int NUM_TAPS  = 7;
    localparam int DIV_W     = 7;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 8;
    localparam int ROUTE_W   = NUM_OUT * SEL_W;
    localparam int ROUTE_TL  = ROUTE_W - 2 * DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_OE     = 8'h09;
    localparam logic [ADDR_W-1:0] ADDR_BANK1  = 8'h0C;
    localparam logic [ADDR_W-1:0] ADDR_ROUTE0 = 8'h44;
    localparam logic [ADDR_W-1:0] ADDR_ROUTE1 = 8'h45;
    localparam logic [ADDR_W-1:0] ADDR_ROUTE2 = 8'h46;
    localparam logic [ADDR_W-1:0] ADDR_BANK2  = 8'h47;

    typedef enum logic [SEL_W-1:0] {
        TAP_REF  = 3'd0,
        TAP_B1_N = 3'd1,
        TAP_B1_2 = 3'd2,
        TAP_B1_F = 3'd3,
        TAP_B2_N = 3'd4,
        TAP_B2_2 = 3'd5,
        TAP_B2_F = 3'd6,
        TAP_OFF  = 3'd7
    } tap_sel_e;

    typedef struct packed {
        logic             src_vco;
        logic [DIV_W-1:0] div;
    } bank_cfg_t;
endpackage

// File: rtl/clk_xbar_cfg.sv
module clk_xbar_cfg
    import clk_xbar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_OUT-1:0]  oe,
    output bank_cfg_t           bank1,
    output bank_cfg_t           bank2,
    output logic [ROUTE_W-1:0]  route
);
    typedef struct packed {
        logic [NUM_OUT-1:0]  oe;
        bank_cfg_t           b1;
        bank_cfg_t           b2;
        logic [DATA_W-1:0]   r0;
        logic [DATA_W-1:0]   r1;
        logic [ROUTE_TL-1:0] r2;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        st_d = st_q;
        hit  = 1'b0;
        if (wr_en) begin
            case (addr)
                ADDR_OE: begin
                    st_d.oe = wdata[NUM_OUT-1:0];
                    hit     = 1'b1;
                end
                ADDR_BANK1: begin
                    st_d.b1 = bank_cfg_t'(wdata);
                    hit     = 1'b1;
                end
                ADDR_BANK2: begin
                    st_d.b2 = bank_cfg_t'(wdata);
                    hit     = 1'b1;
                end
                ADDR_ROUTE0: begin
                    st_d.r0 = wdata;
                    hit     = 1'b1;
                end
                ADDR_ROUTE1: begin
                    st_d.r1 = wdata;
                    hit     = 1'b1;
                end
                ADDR_ROUTE2: begin
                    st_d.r2 = wdata[DATA_W-1 -: ROUTE_TL];
                    hit     = 1'b1;
                end
                default: hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign oe    = st_q.oe;
    assign bank1 = st_q.b1;
    assign bank2 = st_q.b2;
    assign route = {st_q.r0, st_q.r1, st_q.r2};

    // R10
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(st_q));
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
    import clk_xbar_pkg::*;
#(
    parameter int FIX_DIV = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_tick,
    input  bank_cfg_t cfg,
    output logic      tap_n,
    output logic      tap_2,
    output logic      tap_f
);
    localparam int FW = (FIX_DIV > 2) ? $clog2(FIX_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [FW-1:0]    fcnt;
        logic [DIV_W-1:0] n_act;
        logic             src_vco;
        logic             tn;
        logic             t2;
        logic             tf;
    } bank_state_t;

    bank_state_t      st_d, st_q;
    logic             tick;
    logic             term;
    logic [DIV_W-1:0] n_eff;

    always_comb begin
        st_d  = st_q;
        tick  = st_q.src_vco ? 1'b1 : ref_tick;
        term  = ({1'b0, st_q.cnt} + (DIV_W+1)'(1)) >= {1'b0, st_q.n_act};
        n_eff = st_q.n_act;
        if (tick) begin
            if (term) begin
                st_d.cnt     = '0;
                st_d.fcnt    = '0;
                st_d.n_act   = cfg.div;
                st_d.src_vco = cfg.src_vco;
                n_eff        = cfg.div;
            end else begin
                st_d.cnt  = st_q.cnt + DIV_W'(1);
                st_d.fcnt = (st_q.fcnt == FW'(FIX_DIV-1)) ? '0 : st_q.fcnt + FW'(1);
            end
            st_d.tn = st_d.cnt < (n_eff >> 1);
            st_d.t2 = ~st_d.cnt[0];
            st_d.tf = st_d.fcnt < FW'(FIX_DIV/2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_n = st_q.tn;
    assign tap_2 = st_q.t2;
    assign tap_f = st_q.tf;

    // R9
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick && term) |-> ($stable(st_q.n_act) && $stable(st_q.src_vco)));

    // R3
    period_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tn) |-> (st_q.cnt == '0));

    // R6
    half_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tn) |-> st_q.t2);

    // R11
    tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(st_q.tn) && $stable(st_q.cnt)));
endmodule

// File: rtl/clk_xbar_lane.sv
module clk_xbar_lane
    import clk_xbar_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]    sel,
    input  logic                en,
    output logic                clk_o
);
    localparam int EXT_W = 1 << SEL_W;

    typedef struct packed {
        logic out;
    } lane_state_t;

    lane_state_t      st_d, st_q;
    logic [EXT_W-1:0] ext;

    always_comb begin
        ext        = {{(EXT_W-NUM_TAPS){1'b0}}, taps};
        st_d.out   = en & ext[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_o = st_q.out;

    // R8
    reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel) == TAP_OFF) |-> !clk_o);

    // R2
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> !clk_o);
endmodule

// File: rtl/clk_xbar.sv
module clk_xbar
    import clk_xbar_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_i,
    input  logic               cfg_wr_en,
    input  logic [7:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [5:0]         clk_o,
    output logic [5:0]         oe_o
);
    typedef struct packed {
        logic s1;
        logic s2;
    } ref_state_t;

    ref_state_t           rs_d, rs_q;
    logic                 ref_tick;
    logic [NUM_OUT-1:0]   oe;
    bank_cfg_t            b1_cfg, b2_cfg;
    logic [ROUTE_W-1:0]   route;
    logic                 b1_n, b1_2, b1_f, b2_n, b2_2, b2_f;
    logic [NUM_TAPS-1:0]  taps;

    always_comb begin
        rs_d.s1  = ref_i;
        rs_d.s2  = rs_q.s1;
        ref_tick = rs_q.s1 & ~rs_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    clk_xbar_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .oe    (oe),
        .bank1 (b1_cfg),
        .bank2 (b2_cfg),
        .route (route)
    );

    clk_div_bank #(.FIX_DIV(3)) u_bank1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .cfg      (b1_cfg),
        .tap_n    (b1_n),
        .tap_2    (b1_2),
        .tap_f    (b1_f)
    );

    clk_div_bank #(.FIX_DIV(4)) u_bank2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .cfg      (b2_cfg),
        .tap_n    (b2_n),
        .tap_2    (b2_2),
        .tap_f    (b2_f)
    );

    assign taps = {b2_f, b2_2, b2_n, b1_f, b1_2, b1_n, rs_q.s1};

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
        clk_xbar_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .taps  (taps),
            .sel   (route[ROUTE_W-1-SEL_W*i -: SEL_W]),
            .en    (oe[i]),
            .clk_o (clk_o[i])
        );
    end

    assign oe_o = oe;
endmodule

// File: tb/clk_xbar_test.sv
module clk_xbar_test;
    localparam int CLK_PERIOD = 10;
    localparam int REF_HALF   = 3;
    localparam int LIM        = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_i = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [5:0] clk_o;
    logic [5:0] oe_o;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    clk_xbar uut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i),
        .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .clk_o(clk_o), .oe_o(oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (REF_HALF) @(negedge clk);
            ref_i = ~ref_i;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic measure(input int idx, output int hi, output int per);
        int guard = 0;
        int lo = 0;
        logic prev, cur;
        bit rise = 0;
        hi = 0;
        prev = clk_o[idx];
        do begin
            @(negedge clk);
            cur = clk_o[idx];
            rise = !prev && cur;
            prev = cur;
            guard++;
        end while (!rise && guard < LIM);
        while (clk_o[idx] && guard < LIM) begin hi++; @(negedge clk); guard++; end
        while (!clk_o[idx] && guard < LIM) begin lo++; @(negedge clk); guard++; end
        per = hi + lo;
    endtask

    task automatic align(input int a, input int b, input int win, output int rises, output int bad);
        logic pa, pb;
        rises = 0; bad = 0;
        @(negedge clk);
        pa = clk_o[a]; pb = clk_o[b];
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (!pa && clk_o[a]) begin
                rises++;
                if (!(!pb && clk_o[b])) bad++;
            end
            pa = clk_o[a]; pb = clk_o[b];
        end
    endtask

    task automatic count_high(input int idx, input int win, output int highs);
        highs = 0;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (clk_o[idx]) highs++;
        end
    endtask

    task automatic runs(input int idx, input int win, input int wa, input int wb, output int bad, output int seen);
        logic prev;
        int len = 0;
        bit first = 1;
        bad = 0; seen = 0;
        @(negedge clk);
        prev = clk_o[idx];
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (clk_o[idx] == prev) len++;
            else begin
                if (!first) begin
                    seen++;
                    if (len != wa && len != wb) bad++;
                end
                first = 0;
                len = 1;
                prev = clk_o[idx];
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int hi, per, r, bad, h, seen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(oe_o == 6'd0, "R1", oe_o, 0, "oe after reset");
        chk(clk_o == 6'd0, "R1", clk_o, 0, "clk after reset");

        // R7: lanes 0..5 get codes 1,2,3,4,5,6
        wr(8'h44, 8'h29); wr(8'h45, 8'hCB); wr(8'h46, 8'h80);
        wr(8'h0C, 8'h80 | 8'd8); wr(8'h47, 8'h80 | 8'd8);
        repeat (30) @(negedge clk);
        chk(clk_o == 6'd0, "R1", clk_o, 0, "clk before enable");
        chk(oe_o == 6'd0, "R1", oe_o, 0, "oe before enable");
        wr(8'h09, 8'h3F);
        chk(oe_o == 6'h3F, "R2", oe_o, 63, "oe after enable");

        // R3 R4 R5 R6 R7: sweep N on both banks from the VCO
        for (int n = 4; n <= 24; n++) begin
            wr(8'h0C, 8'h80 | 8'(n)); wr(8'h47, 8'h80 | 8'(n));
            repeat (3 * n + 10) @(negedge clk);
            measure(0, hi, per);
            chk(per == n, "R3", per, n, $sformatf("bank1 /N period N=%0d", n));
            chk(hi == n / 2, "R4", hi, n / 2, $sformatf("bank1 /N high N=%0d", n));
            measure(3, hi, per);
            chk(per == n, "R3", per, n, $sformatf("bank2 /N period N=%0d", n));
            chk(hi == n / 2, "R4", hi, n / 2, $sformatf("bank2 /N high N=%0d", n));
            if (n % 2 == 0) begin
                measure(1, hi, per);
                chk(per == 2 && hi == 1, "R5", per, 2, "bank1 /2 period");
                measure(4, hi, per);
                chk(per == 2 && hi == 1, "R5", per, 2, "bank2 /2 period");
            end
            if (n % 3 == 0) begin
                measure(2, hi, per);
                chk(per == 3 && hi == 1, "R5", per, 3, "bank1 /3 period");
            end
            if (n % 4 == 0) begin
                measure(5, hi, per);
                chk(per == 4 && hi == 2, "R5", per, 4, "bank2 /4 period");
                align(0, 1, 3 * n, r, bad);
                chk(bad == 0 && r > 0, "R6", bad, 0, $sformatf("bank1 /2 align N=%0d", n));
                align(3, 4, 3 * n, r, bad);
                chk(bad == 0 && r > 0, "R6", bad, 0, $sformatf("bank2 /2 align N=%0d", n));
            end
            if (n % 8 == 0) begin
                align(3, 5, 3 * n, r, bad);
                chk(bad == 0 && r > 0, "R6", bad, 0, $sformatf("bank2 /4 align N=%0d", n));
            end
            if (n == 6) begin
                align(0, 2, 3 * n, r, bad);
                chk(bad == 0 && r > 0, "R6", bad, 0, "bank1 /3 align N=6");
            end
        end

        // R3 R4: top of the divisor range
        wr(8'h0C, 8'hFF); wr(8'h47, 8'hFF);
        repeat (300) @(negedge clk);
        measure(0, hi, per);
        chk(per == 127 && hi == 63, "R4", per, 127, "bank1 N=127");
        measure(3, hi, per);
        chk(per == 127 && hi == 63, "R4", per, 127, "bank2 N=127");

        // R10: writes to unmapped addresses change nothing
        wr(8'h0C, 8'h89); wr(8'h47, 8'h89);
        repeat (300) @(negedge clk);
        wr(8'h08, 8'h00); wr(8'h0B, 8'h00); wr(8'h43, 8'h00); wr(8'h48, 8'h00); wr(8'h13, 8'hFF);
        chk(oe_o == 6'h3F, "R10", oe_o, 63, "oe after unmapped writes");
        repeat (30) @(negedge clk);
        measure(0, hi, per);
        chk(per == 9 && hi == 4, "R10", per, 9, "bank1 after unmapped writes");
        measure(3, hi, per);
        chk(per == 9 && hi == 4, "R10", per, 9, "bank2 after unmapped writes");

        // R2: disabled lane is low and not driven
        wr(8'h09, 8'h3E);
        chk(oe_o == 6'h3E, "R2", oe_o, 62, "oe with lane 0 off");
        @(negedge clk);
        count_high(0, 40, h);
        chk(h == 0, "R2", h, 0, "disabled lane high samples");

        // R8: code 7 is low even when enabled
        wr(8'h09, 8'h3F);
        wr(8'h44, 8'hE9);
        @(negedge clk);
        count_high(0, 40, h);
        chk(h == 0, "R8", h, 0, "reserved code high samples");
        chk(oe_o[0] == 1'b1, "R8", oe_o[0], 1, "oe with reserved code");

        // R11: code 0 passes REF
        wr(8'h44, 8'h09);
        repeat (10) @(negedge clk);
        measure(0, hi, per);
        chk(per == 2 * REF_HALF && hi == REF_HALF, "R11", per, 2 * REF_HALF, "raw REF on lane 0");

        // R11 R3: bank 1 counting REF edges, N=5
        wr(8'h44, 8'h29);
        wr(8'h0C, 8'h05);
        repeat (200) @(negedge clk);
        measure(0, hi, per);
        chk(per == 5 * 2 * REF_HALF, "R11", per, 5 * 2 * REF_HALF, "bank1 REF source period");
        chk(hi == 2 * 2 * REF_HALF, "R11", hi, 2 * 2 * REF_HALF, "bank1 REF source high");

        // R9: divisor change lands at terminal count, no short phase
        wr(8'h0C, 8'h8A);
        repeat (200) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(8'h0C, 8'h86);
        runs(0, 80, 5, 3, bad, seen);
        chk(bad == 0 && seen > 4, "R9", bad, 0, "phase widths across N change");
        measure(0, hi, per);
        chk(per == 6 && hi == 3, "R9", per, 6, "period after N change");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule